// File: doc/BRIEF.md
# Regulator Enable and Low-Voltage Interrupt Controller

This block holds one 8-bit control register. From that register and the current sleep state it decides whether an on-chip voltage regulator runs. It also gates a low-voltage interrupt that comes from a battery comparator. Two fields of the register go straight to the analog side: the regulator output voltage select and the comparator threshold select. The block also presents an effective threshold code, which resolves the threshold field's "follow the regulator output" setting into a concrete level.

Software writes the register through a single-address write strobe. The contents can be read back at any time on a combinational read bus. The sleep input and the comparator input are plain levels. The regulator enable and the interrupt request are combinational levels derived from the register and those inputs.

Top module: `pmu_gate_ctrl`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at the clock edge. Register bit 7 is the regulator enable, bit 6 is the interrupt enable, bit 5 is the force bit, bits 3:2 are the threshold field and bits 1:0 are the output voltage field. Bit 4 is not stored and always reads 0 on `rd_data`.
- R2: After reset `rd_data` reads 8'hA0 (enable 1, interrupt enable 0, force 1, both fields 0).
- R3: With enable 1 and force 1, `reg_en` is 1 whether or not `sleep` is high.
- R4: With enable 1 and force 0, `reg_en` equals the inverse of `sleep`.
- R5: With enable 0, `reg_en` is 0 for either value of force and of `sleep`.
- R6: `lv_irq` is 1 exactly when the interrupt enable is 1, `vbat_low` is 1, `sleep` is 0 and `reg_en` is 1. Otherwise it is 0.
- R7: `thr_sel` shows register bits 3:2 and `vout_sel` shows bits 1:0. For `vout_sel`, 11=2.4 V, 10=2.5 V, 01=2.6 V and 00=2.7 V. For `thr_sel`, 11=1.8 V, 10=2.0 V, 01=2.2 V and 00 means "use the regulator output level".
- R8: `eff_thr` codes the comparator level in ascending voltage order: 0=1.8, 1=2.0, 2=2.2, 3=2.4, 4=2.5, 5=2.6, 6=2.7 V. It equals 3 - `thr_sel` when `thr_sel` is nonzero, and 6 - `vout_sel` otherwise.
- R9: While `wr_en` is low the register holds its value, whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| sleep | input | 1 | Device sleep state |
| vbat_low | input | 1 | Comparator: battery below the selected threshold |
| reg_en | output | 1 | Regulator enable |
| lv_irq | output | 1 | Low-voltage interrupt request (level) |
| thr_sel | output | 2 | Threshold select to the comparator |
| vout_sel | output | 2 | Output voltage select to the regulator |
| eff_thr | output | 3 | Effective threshold level code |

## Verification
A write becomes visible one clock edge after the strobe is sampled. From that edge on, every output is a combinational function of the register and of `sleep` and `vbat_low`, so each output is due in that same cycle. The bench therefore drives inputs on the falling edge and lets a rising edge capture any write. It checks on the next falling edge, half a cycle after the register updates and after the last input change. Every one of the 256 write values is swept against all four combinations of sleep and comparator input, with the expected values computed from the field arithmetic.

// File: rtl/pmu_gate_ctrl.sv
module pmu_gate_ctrl #(
  parameter logic [7:0] RESET_VAL = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sleep,
  input  logic       vbat_low,
  output logic       reg_en,
  output logic       lv_irq,
  output logic [1:0] thr_sel,
  output logic [1:0] vout_sel,
  output logic [2:0] eff_thr
);
  localparam logic [7:0] KEEP_MASK = 8'hEF;

  logic [7:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= RESET_VAL & KEEP_MASK;
    else if (wr_en) ctrl_q <= wr_data & KEEP_MASK;
  end

  wire en_bit    = ctrl_q[7];
  wire irq_en    = ctrl_q[6];
  wire force_bit = ctrl_q[5];

  assign rd_data  = ctrl_q;
  assign thr_sel  = ctrl_q[3:2];
  assign vout_sel = ctrl_q[1:0];
  assign reg_en   = en_bit & (force_bit | ~sleep);
  assign lv_irq   = irq_en & vbat_low & reg_en & ~sleep;

  always_comb begin
    if (thr_sel != 2'b00) eff_thr = 3'd3 - {1'b0, thr_sel};
    else                  eff_thr = 3'd6 - {1'b0, vout_sel};
  end
endmodule

module pmu_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sleep,
  input logic       vbat_low,
  input logic       reg_en,
  input logic       lv_irq,
  input logic [1:0] thr_sel,
  input logic [2:0] eff_thr
);
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |-> rd_data == ($past(wr_data) & 8'hEF));
  a_r1_bit4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] == 1'b0);
  a_r3_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && rd_data[5]) |-> reg_en);
  a_r4_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !rd_data[5]) |-> !reg_en);
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> !reg_en);
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    lv_irq |-> (!sleep && reg_en && vbat_low && rd_data[6]));
  a_r8_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel != 2'b00) |-> eff_thr < 3'd3);
  a_r8_follow_out: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel == 2'b00) |-> (eff_thr >= 3'd3 && eff_thr <= 3'd6));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |-> $stable(rd_data));
endmodule

bind pmu_gate_ctrl pmu_gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sleep(sleep), .vbat_low(vbat_low),
  .reg_en(reg_en), .lv_irq(lv_irq), .thr_sel(thr_sel), .eff_thr(eff_thr)
);

// File: tb/test_pmu_gate_ctrl.sv
module test_pmu_gate_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic sleep = 1'b0;
  logic vbat_low = 1'b0;
  logic [7:0] rd_data;
  logic reg_en, lv_irq;
  logic [1:0] thr_sel, vout_sel;
  logic [2:0] eff_thr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmu_gate_ctrl i_pmu_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep(sleep), .vbat_low(vbat_low),
    .reg_en(reg_en), .lv_irq(lv_irq), .thr_sel(thr_sel),
    .vout_sel(vout_sel), .eff_thr(eff_thr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input logic [7:0] v);
    logic [7:0] exp_rd;
    logic exp_en, exp_irq;
    int exp_eff;
    exp_rd = v & 8'hEF;
    check(rd_data === exp_rd, "R1", rd_data, exp_rd);
    if (!v[7]) begin
      exp_en = 1'b0;
      check(reg_en === exp_en, "R5", reg_en, exp_en);
    end else if (v[5]) begin
      exp_en = 1'b1;
      check(reg_en === exp_en, "R3", reg_en, exp_en);
    end else begin
      exp_en = !sleep;
      check(reg_en === exp_en, "R4", reg_en, exp_en);
    end
    exp_irq = v[6] && vbat_low && !sleep && exp_en;
    check(lv_irq === exp_irq, "R6", lv_irq, exp_irq);
    check(thr_sel === v[3:2] && vout_sel === v[1:0], "R7", {thr_sel, vout_sel}, v[3:0]);
    exp_eff = (v[3:2] != 0) ? 3 - int'(v[3:2]) : 6 - int'(v[1:0]);
    check(int'(eff_thr) == exp_eff, "R8", eff_thr, exp_eff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === 8'hA0, "R2", rd_data, 8'hA0);
    check(reg_en === 1'b1, "R2", reg_en, 1);
    check(eff_thr === 3'd6, "R2", eff_thr, 6);
    check(lv_irq === 1'b0, "R2", lv_irq, 0);
    for (int v = 0; v < 256; v++) begin
      write_reg(v[7:0]);
      for (int s = 0; s < 4; s++) begin
        sleep = s[0];
        vbat_low = s[1];
        #1;
        check_all(v[7:0]);
      end
      sleep = 1'b0;
      vbat_low = 1'b0;
    end
    write_reg(8'hC6);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_data = 8'h39 ^ k[7:0];
      @(negedge clk);
      check(rd_data === 8'hC6, "R9", rd_data, 8'hC6);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule